// File: doc/BRIEF.md
# One-of-Four Transition Link Codec

This block is a synchronous transmitter and receiver pair joined by a four-wire, level-encoded signalling link and one acknowledge wire. The transmitter takes a 2-bit symbol on a valid/ready handshake. For each symbol it flips exactly one of the four link wires. Which wire it flips depends on the value now carried by the wires and on the new symbol. It then holds off further symbols until it sees the acknowledge wire change level.

The receiver watches the link wires through a synchronizer. It recognises a new symbol when the XOR of all four wires differs from the parity it recorded at its last capture. It then decodes the 2-bit value from the present wire levels alone, pulses a valid output for one cycle and flips the acknowledge wire. The acknowledge wire also passes through a synchronizer on its way back to the transmitter.

All sixteen wire states are legal codewords. With the lane count set to two, the same logic becomes the classic dual-rail scheme: one parity rail and one data rail, carrying one bit per transition.

Top module: `onefour_link`

## Requirements
- R1: Each accepted symbol changes exactly one link wire, and no two consecutive link states differ in more than one wire.
- R2: Each transfer carries a symbol of log2(LANES) bits (2 bits at the default of four lanes), and the receiver delivers the same symbol value that was accepted.
- R3: The received value depends only on the present wire levels. For four lanes the value is {w[1]^w[3], w[2]^w[3]}; for two lanes it is w[1].
- R4: The transmitter forms x = (value now decoded from the wires) XOR (new symbol). It flips w[0] when x=00, w[1] when x=10, w[2] when x=01 and w[3] when x=11, so a repeat of the current value flips w[0].
- R5: The XOR of all link wires alternates on every accepted symbol. The receiver raises out_valid for exactly one cycle per symbol, in order, SYNC_STAGES+1 cycles after the acceptance edge.
- R6: in_ready falls in the cycle after an acceptance. It stays low until the transmitter sees the acknowledge wire change, and returns 2*SYNC_STAGES+2 cycles after the acceptance edge.
- R7: During and right after synchronous reset, all link wires, the acknowledge wire, out_valid and out_data are 0, and in_ready is 1.
- R8: With LANES=2, w[0] acts as the parity rail and w[1] carries the data bit, one bit per transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Transmit symbol offered |
| in_data | input | SYM_W | Transmit symbol |
| in_ready | output | 1 | Transmitter can accept a symbol |
| out_valid | output | 1 | One-cycle pulse with a received symbol |
| out_data | output | SYM_W | Received symbol |
| link_wires | output | LANES | Link wire levels driven by the transmitter |
| link_ack | output | 1 | Acknowledge wire driven by the receiver |

## Verification
Long runs of one repeated value exercise the w[0]-only toggle path and show that capture is triggered by parity and not by a change of value. A sweep over every ordered pair of symbols covers each of the four XOR cases in the encode table. Each case has its expected wire and its decoded level checked. Random symbols with random idle gaps show that delivery order, pulse timing and ready timing hold under irregular offers. A two-lane instance, driven in parallel with bit 0 of the same stream, shows that the scheme collapses to dual-rail.

// File: rtl/link_pkg.sv
package link_pkg;

    localparam int MAX_LANES = 16;
    localparam int MAX_SYM   = 4;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_WAIT = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic                valid;
        logic [MAX_SYM-1:0]  value;
    } rx_capture_t;

    // Value bit (symw-1-k) is the XOR of every wire whose index has bit k set.
    function automatic logic [MAX_SYM-1:0] lvl_decode(
        input logic [MAX_LANES-1:0] w,
        input int                   symw
    );
        logic [MAX_SYM-1:0] v;
        v = '0;
        for (int k = 0; k < MAX_SYM; k++) begin
            if (k < symw) begin
                for (int i = 0; i < MAX_LANES; i++) begin
                    if (((i >> k) & 1) == 1)
                        v[symw-1-k] = v[symw-1-k] ^ w[i];
                end
            end
        end
        return v;
    endfunction

    // Wire to flip for a value change x: its index is x with bits reversed.
    function automatic logic [MAX_LANES-1:0] flip_mask(
        input logic [MAX_SYM-1:0] x,
        input int                 symw
    );
        int idx;
        idx = 0;
        for (int k = 0; k < MAX_SYM; k++) begin
            if (k < symw && x[k])
                idx = idx | (1 << (symw - 1 - k));
        end
        return MAX_LANES'(1) << idx;
    endfunction

endpackage

// File: rtl/link_sync.sv
module link_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= '0;
                else if (s == 0)
                    stg[s] <= d;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/link_tx.sv
module link_tx
    import link_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SYM_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    input  logic             ack_in,
    output logic [LANES-1:0] wires_out
);
    tx_state_e            st_q;
    logic [LANES-1:0]     w_q;
    logic                 ack_seen_q;
    logic [MAX_SYM-1:0]   cur_full;
    logic [SYM_W-1:0]     delta;
    logic [MAX_LANES-1:0] mask_full;
    logic [LANES-1:0]     w_next;

    always_comb begin
        cur_full  = lvl_decode(MAX_LANES'(w_q), SYM_W);
        delta     = cur_full[SYM_W-1:0] ^ in_data;
        mask_full = flip_mask(MAX_SYM'(delta), SYM_W);
        w_next    = w_q ^ mask_full[LANES-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= TX_IDLE;
            w_q        <= '0;
            ack_seen_q <= 1'b0;
        end else begin
            case (st_q)
                TX_IDLE: if (in_valid) begin
                    w_q  <= w_next;
                    st_q <= TX_WAIT;
                end
                TX_WAIT: if (ack_in != ack_seen_q) begin
                    ack_seen_q <= ack_in;
                    st_q       <= TX_IDLE;
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign in_ready  = (st_q == TX_IDLE);
    assign wires_out = w_q;

    // R1: consecutive link states never differ in more than one wire
    assert_one_wire_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(w_q ^ $past(w_q)) <= 1);

    // R6: ready drops in the cycle after an acceptance
    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/link_rx.sv
module link_rx
    import link_pkg::*;
#(
    parameter int LANES = 4,
    localparam int SYM_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] wires_in,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             ack_out
);
    rx_capture_t        cap_q;
    logic               par_q;
    logic               ack_q;
    logic               par_now;
    logic [MAX_SYM-1:0] dec;

    always_comb begin
        par_now = ^wires_in;
        dec     = lvl_decode(MAX_LANES'(wires_in), SYM_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            par_q <= 1'b0;
            ack_q <= 1'b0;
        end else if (par_now != par_q) begin
            par_q       <= par_now;
            cap_q.valid <= 1'b1;
            cap_q.value <= dec;
            ack_q       <= ~ack_q;
        end else begin
            cap_q.valid <= 1'b0;
        end
    end

    assign out_valid = cap_q.valid;
    assign out_data  = cap_q.value[SYM_W-1:0];
    assign ack_out   = ack_q;

    // R5: one capture per symbol, never two in consecutive cycles
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/onefour_link.sv
module onefour_link
    import link_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SYM_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic [LANES-1:0] link_wires,
    output logic             link_ack
);
    logic [LANES-1:0] wires_rx;
    logic [0:0]       ack_tx;

    link_tx #(.LANES(LANES)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .ack_in    (ack_tx[0]),
        .wires_out (link_wires)
    );

    link_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync_fwd (
        .clk (clk),
        .rst (rst),
        .d   (link_wires),
        .q   (wires_rx)
    );

    link_rx #(.LANES(LANES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .wires_in  (wires_rx),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ack_out   (link_ack)
    );

    link_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_back (
        .clk (clk),
        .rst (rst),
        .d   (link_ack),
        .q   (ack_tx)
    );

    logic [MAX_SYM-1:0] link_val;
    assign link_val = lvl_decode(MAX_LANES'(link_wires), SYM_W);

    // R5: wire parity alternates on every accepted symbol
    assert_parity_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ((^link_wires) != $past(^link_wires)));

    // R3: after an acceptance the wire levels alone carry the new symbol
    assert_level_value_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (link_val[SYM_W-1:0] == $past(in_data)));

endmodule

// File: tb/onefour_link_bench.sv
module onefour_link_bench;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_data = 2'b00;
    logic       in_ready, out_valid, link_ack;
    logic [1:0] out_data;
    logic [3:0] link_wires;
    logic       rdy2, ov2, ack2;
    logic [0:0] od2;
    logic [1:0] w2;

    always #10 clk = ~clk;

    onefour_link #(.LANES(4), .SYNC_STAGES(SYNC)) u_onefour_link (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .link_wires(link_wires), .link_ack(link_ack));

    onefour_link #(.LANES(2), .SYNC_STAGES(SYNC)) u_dual (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data[0]),
        .in_ready(rdy2), .out_valid(ov2), .out_data(od2),
        .link_wires(w2), .link_ack(ack2));

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] val4(input logic [3:0] w);
        return {w[1] ^ w[3], w[2] ^ w[3]};
    endfunction

    typedef struct {
        int         due;
        logic [1:0] d;
    } pend_t;

    pend_t      q[$];
    int         cyc = 0;
    int         ready_at = 0;
    logic [3:0] prev_w = '0;
    logic [1:0] prev_w2 = '0;
    logic [3:0] exp_w = '0;
    logic [1:0] last_d = '0;
    bit         acc_last = 1'b0;

    // behavioural reference, compared on every clock
    always @(negedge clk) begin
        if (rst) begin
            check(link_wires == 0 && link_ack == 0 && out_valid == 0 && out_data == 0 && in_ready == 1,
                  "R7", {link_wires, link_ack, out_valid, out_data, in_ready}, 1);
            prev_w  = '0;
            prev_w2 = '0;
            acc_last = 1'b0;
        end else begin
            cyc++;
            check($countones(link_wires ^ prev_w) <= 1, "R1", link_wires, prev_w);
            check($countones(w2 ^ prev_w2) <= 1, "R8 one-rail", w2, prev_w2);
            if (acc_last) begin
                check(link_wires == exp_w, "R4", link_wires, exp_w);
                check(val4(link_wires) == last_d, "R3", val4(link_wires), last_d);
                check((^link_wires) != (^prev_w), "R5 parity", ^link_wires, ^prev_w);
                check(w2[1] == last_d[0] && (^w2) != (^prev_w2), "R8 data rail", w2, last_d[0]);
            end else begin
                check(link_wires == prev_w, "R1 idle", link_wires, prev_w);
            end
            check(in_ready == (cyc >= ready_at), "R6", in_ready, cyc >= ready_at);
            begin
                bit eov;
                eov = (q.size() > 0) && (q[0].due == cyc);
                check(out_valid == eov, "R5 timing", out_valid, eov);
                check(ov2 == eov, "R8 valid", ov2, eov);
                if (eov) begin
                    check(out_data == q[0].d, "R2", out_data, q[0].d);
                    check(od2[0] == q[0].d[0], "R8 value", od2, q[0].d[0]);
                    void'(q.pop_front());
                end
            end
            acc_last = in_valid && in_ready;
            if (acc_last) begin
                logic [1:0] x;
                int idx;
                x = val4(link_wires) ^ in_data;
                case (x)
                    2'b00:   idx = 0;
                    2'b10:   idx = 1;
                    2'b01:   idx = 2;
                    default: idx = 3;
                endcase
                exp_w  = link_wires ^ (4'b0001 << idx);
                last_d = in_data;
                q.push_back('{cyc + SYNC + 2, in_data});
                ready_at = cyc + 2 * SYNC + 3;
            end
            prev_w  = link_wires;
            prev_w2 = w2;
        end
    end

    task automatic send(input logic [1:0] d);
        @(posedge clk);
        #2;
        in_valid = 1'b1;
        in_data  = d;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // repeated values: R4 w0-only path, R5 parity-triggered capture
        for (int i = 0; i < 5; i++) send(2'b00);
        for (int i = 0; i < 4; i++) send(2'b11);
        // every ordered pair: all XOR cases of R4
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                send(2'(a));
                send(2'(b));
            end
        // random symbols with random gaps (R2, R5, R6)
        for (int i = 0; i < 200; i++) begin
            send(2'($urandom_range(0, 3)));
            repeat ($urandom_range(0, 3)) @(posedge clk);
        end
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(q.size() == 0, "R5 all delivered", q.size(), 0);
        finish_run();
    end
endmodule